// File: doc/BRIEF.md
# Panel Power and Backlight Sequencer

This controller brings a flat-panel display module up and takes it down in a safe order. It drives three enables: the module logic supply, the output enable of the interface-signal drivers, and the backlight inverter. A host holds a level request high to ask for the panel to be on and drops it to ask for it to be off. A power-good input tells the controller that the supply has reached 90 percent of its final value.

All waits are whole milliseconds. A prescaler, restarted at the start of each wait, turns the reference clock into millisecond ticks, and a single down-counter measures each wait. The supply ramp has a deadline. If power-good misses it, the controller removes the supply, raises a fault flag and falls back to the off path. Each supply-off period has a guaranteed minimum length, counted from reset as well. The lamp strike drive is held for a fixed time. A dimming-mode output selects duty-based dimming whenever the requested lamp current is low.

Top module: `panel_seq_top`

## Requirements
- R1: During reset and in the first cycle after it, every output is low. After reset the supply enable stays low for OFF_HOLD_MS milliseconds plus one cycle, counted from the last reset edge, even if the request is high.
- R2: When the controller is idle with the supply off and the minimum off time has passed, a high request raises `vdd_en` in the next cycle.
- R3: If `pwr_good` is still low RAMP_MS milliseconds after `vdd_en` rose, `vdd_en` falls exactly RAMP_MS*CLK_PER_MS cycles after it rose, and `fault` rises in that same cycle. `fault` stays high until `vdd_en` next rises, and then it clears.
- R4: `sig_oe` rises in the cycle after `pwr_good` is sampled high during the ramp. `sig_oe` is never high while `vdd_en` is low.
- R5: After `vdd_en` falls, it stays low for at least OFF_HOLD_MS*CLK_PER_MS cycles. When the request is already high, it rises again exactly OFF_HOLD_MS*CLK_PER_MS+1 cycles after it fell.
- R6: `lamp_en` rises LAMP_ON_WAIT_MS*CLK_PER_MS+1 cycles after `sig_oe` rises, and it is never high while `sig_oe` is low.
- R7: `lamp_strike` rises together with `lamp_en` and stays high for exactly STRIKE_MS*CLK_PER_MS cycles. It is only high while `lamp_en` is high. When the strike ends with the request still high, `running` goes high and `lamp_en` stays high.
- R8: If the request drops while `running` is high, `lamp_en` falls in the next cycle. `sig_oe` falls LAMP_OFF_WAIT_MS*CLK_PER_MS cycles after that, and `vdd_en` falls one cycle after `sig_oe`.
- R9: A request drop during power-up takes effect only when the current step ends. During the ramp, `sig_oe` still rises on power-good, falls one cycle later, and `vdd_en` falls one cycle after that; the lamp stays off. During the strike, the strike runs its full length, after which `lamp_en` falls and `running` stays low.
- R10: `dim_duty` is high one cycle after `lamp_set` (lamp current in 0.1 mA units) is below DIM_LIMIT (default 40, that is 4.0 mA), and low one cycle after it is at or above that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Host level request: 1 = panel on, 0 = panel off |
| pwr_good | input | 1 | Supply has reached 90 percent |
| lamp_set | input | LAMP_W | Requested lamp current in 0.1 mA units |
| vdd_en | output | 1 | Logic supply enable |
| sig_oe | output | 1 | Interface-signal output enable (drivers low or high-impedance when 0) |
| lamp_en | output | 1 | Backlight inverter enable |
| lamp_strike | output | 1 | Lamp kick-off drive |
| dim_duty | output | 1 | Duty-based dimming selected |
| running | output | 1 | Panel fully on, strike finished |
| fault | output | 1 | Supply ramp deadline missed |

## Verification
Every output is decoded from a registered state, so an input sampled at a rising edge is visible at the following falling edge. A timed step lasts exactly its millisecond count times CLK_PER_MS cycles, because the prescaler restarts when the step is entered. The bench drives inputs and samples outputs at falling edges. It counts falling edges from the stimulus until the watched output changes and compares that count with the cycle figure in the requirement, for example LAMP_ON_WAIT_MS*CLK_PER_MS+1 from `sig_oe` to `lamp_en`. Random power-good delays span the whole ramp window up to its last legal cycle, and each dimming setting is checked one cycle after it is driven.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_VDD_RAMP,
        ST_SIG_ON,
        ST_LAMP_WAIT,
        ST_LAMP_STRIKE,
        ST_RUN,
        ST_LAMP_OFF,
        ST_SIG_OFF,
        ST_OFF_HOLD
    } seq_state_e;

    typedef struct packed {
        logic vdd;
        logic sig;
        logic lamp;
        logic strike;
        logic run;
    } drive_t;

    function automatic drive_t drive_of(seq_state_e s);
        drive_t d;
        d = '0;
        case (s)
            ST_VDD_RAMP:    d.vdd = 1'b1;
            ST_SIG_ON,
            ST_LAMP_WAIT,
            ST_LAMP_OFF:    begin d.vdd = 1'b1; d.sig = 1'b1; end
            ST_LAMP_STRIKE: begin d.vdd = 1'b1; d.sig = 1'b1; d.lamp = 1'b1; d.strike = 1'b1; end
            ST_RUN:         begin d.vdd = 1'b1; d.sig = 1'b1; d.lamp = 1'b1; d.run = 1'b1; end
            ST_SIG_OFF:     d.vdd = 1'b1;
            default:        d = '0;
        endcase
        return d;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/panel_seq_tick.sv
module panel_seq_tick #(
    parameter int unsigned CLK_PER_MS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/panel_seq_delay.sv
module panel_seq_delay #(
    parameter int unsigned CW   = 10,
    parameter int unsigned INIT = 150
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] load,
    input  logic          tick,
    output logic          expire
);
    logic [CW-1:0] ms_q;

    assign expire = tick && (ms_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_q <= CW'(INIT);
        end else if (start) begin
            ms_q <= load;
        end else if (tick && (ms_q != '0)) begin
            ms_q <= ms_q - 1'b1;
        end
    end
endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
    import panel_seq_pkg::*;
#(
    parameter int unsigned CW               = 10,
    parameter int unsigned RAMP_MS          = 10,
    parameter int unsigned LAMP_ON_WAIT_MS  = 180,
    parameter int unsigned STRIKE_MS        = 1000,
    parameter int unsigned LAMP_OFF_WAIT_MS = 100,
    parameter int unsigned OFF_HOLD_MS      = 150
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_req,
    input  logic          pwr_good,
    input  logic          expire,
    output logic          start,
    output logic [CW-1:0] load,
    output drive_t        drive,
    output logic          fault
);
    seq_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_OFF:         if (pwr_req) state_n = ST_VDD_RAMP;
            ST_VDD_RAMP: begin
                if (pwr_good)    state_n = ST_SIG_ON;
                else if (expire) state_n = ST_OFF_HOLD;
            end
            ST_SIG_ON:      state_n = pwr_req ? ST_LAMP_WAIT : ST_SIG_OFF;
            ST_LAMP_WAIT:   if (expire) state_n = pwr_req ? ST_LAMP_STRIKE : ST_SIG_OFF;
            ST_LAMP_STRIKE: if (expire) state_n = pwr_req ? ST_RUN : ST_LAMP_OFF;
            ST_RUN:         if (!pwr_req) state_n = ST_LAMP_OFF;
            ST_LAMP_OFF:    if (expire) state_n = ST_SIG_OFF;
            ST_SIG_OFF:     state_n = ST_OFF_HOLD;
            ST_OFF_HOLD:    if (expire) state_n = ST_OFF;
            default:        state_n = ST_OFF_HOLD;
        endcase
    end

    assign start = (state_n != state_q);

    always_comb begin
        case (state_n)
            ST_VDD_RAMP:    load = CW'(RAMP_MS);
            ST_LAMP_WAIT:   load = CW'(LAMP_ON_WAIT_MS);
            ST_LAMP_STRIKE: load = CW'(STRIKE_MS);
            ST_LAMP_OFF:    load = CW'(LAMP_OFF_WAIT_MS);
            ST_OFF_HOLD:    load = CW'(OFF_HOLD_MS);
            default:        load = '0;
        endcase
    end

    assign drive = drive_of(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF_HOLD;
            fault   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_VDD_RAMP && state_n == ST_OFF_HOLD) begin
                fault <= 1'b1;
            end else if (state_q != ST_VDD_RAMP && state_n == ST_VDD_RAMP) begin
                fault <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
    import panel_seq_pkg::*;
#(
    parameter int unsigned CLK_PER_MS       = 125000,
    parameter int unsigned RAMP_MS          = 10,
    parameter int unsigned LAMP_ON_WAIT_MS  = 180,
    parameter int unsigned STRIKE_MS        = 1000,
    parameter int unsigned LAMP_OFF_WAIT_MS = 100,
    parameter int unsigned OFF_HOLD_MS      = 150,
    parameter int unsigned LAMP_W           = 8,
    parameter int unsigned DIM_LIMIT        = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_req,
    input  logic              pwr_good,
    input  logic [LAMP_W-1:0] lamp_set,
    output logic              vdd_en,
    output logic              sig_oe,
    output logic              lamp_en,
    output logic              lamp_strike,
    output logic              dim_duty,
    output logic              running,
    output logic              fault
);
    localparam int unsigned MAX_MS = max2(max2(max2(RAMP_MS, LAMP_ON_WAIT_MS), max2(STRIKE_MS, LAMP_OFF_WAIT_MS)), OFF_HOLD_MS);
    localparam int unsigned CW     = cnt_width(MAX_MS);

    logic          start;
    logic          tick;
    logic          expire;
    logic [CW-1:0] load;
    drive_t        drive;

    panel_seq_tick #(.CLK_PER_MS(CLK_PER_MS)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .tick    (tick)
    );

    panel_seq_delay #(.CW(CW), .INIT(OFF_HOLD_MS)) delay_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .load   (load),
        .tick   (tick),
        .expire (expire)
    );

    panel_seq_ctrl #(
        .CW               (CW),
        .RAMP_MS          (RAMP_MS),
        .LAMP_ON_WAIT_MS  (LAMP_ON_WAIT_MS),
        .STRIKE_MS        (STRIKE_MS),
        .LAMP_OFF_WAIT_MS (LAMP_OFF_WAIT_MS),
        .OFF_HOLD_MS      (OFF_HOLD_MS)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .pwr_req  (pwr_req),
        .pwr_good (pwr_good),
        .expire   (expire),
        .start    (start),
        .load     (load),
        .drive    (drive),
        .fault    (fault)
    );

    assign vdd_en      = drive.vdd;
    assign sig_oe      = drive.sig;
    assign lamp_en     = drive.lamp;
    assign lamp_strike = drive.strike;
    assign running     = drive.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            dim_duty <= 1'b0;
        end else begin
            dim_duty <= (lamp_set < LAMP_W'(DIM_LIMIT));
        end
    end
endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk #(
    parameter int unsigned HOLD_CYC   = 600,
    parameter int unsigned STRIKE_CYC = 4000,
    parameter int unsigned LAMP_W     = 8,
    parameter int unsigned DIM_LIMIT  = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_good,
    input logic [LAMP_W-1:0] lamp_set,
    input logic              vdd_en,
    input logic              sig_oe,
    input logic              lamp_en,
    input logic              lamp_strike,
    input logic              dim_duty,
    input logic              fault
);
    int unsigned off_cnt;
    int unsigned strike_cnt;

    always_ff @(posedge clk) begin
        if (rst || vdd_en) begin
            off_cnt <= 0;
        end else if (off_cnt < HOLD_CYC + 2) begin
            off_cnt <= off_cnt + 1;
        end
        if (rst || !lamp_strike) begin
            strike_cnt <= 0;
        end else if (strike_cnt < STRIKE_CYC + 2) begin
            strike_cnt <= strike_cnt + 1;
        end
    end

    a_r4_sig_needs_vdd: assert property (@(posedge clk) disable iff (rst)
        !vdd_en |-> !sig_oe);

    a_r4_sig_after_good: assert property (@(posedge clk) disable iff (rst)
        $rose(sig_oe) |-> $past(pwr_good));

    a_r6_lamp_needs_sig: assert property (@(posedge clk) disable iff (rst)
        lamp_en |-> sig_oe);

    a_r7_strike_with_lamp: assert property (@(posedge clk) disable iff (rst)
        lamp_strike |-> lamp_en);

    a_r7_strike_len: assert property (@(posedge clk) disable iff (rst)
        $fell(lamp_strike) |-> (strike_cnt == STRIKE_CYC));

    a_r5_min_off: assert property (@(posedge clk) disable iff (rst)
        $rose(vdd_en) |-> (off_cnt >= HOLD_CYC));

    a_r3_fault_drops_vdd: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> (!vdd_en && $past(vdd_en)));

    a_r10_dim_low: assert property (@(posedge clk) disable iff (rst)
        (lamp_set < LAMP_W'(DIM_LIMIT)) |=> dim_duty);

    a_r10_dim_high: assert property (@(posedge clk) disable iff (rst)
        (lamp_set >= LAMP_W'(DIM_LIMIT)) |=> !dim_duty);
endmodule

bind panel_seq_top panel_seq_chk #(
    .HOLD_CYC   (OFF_HOLD_MS * CLK_PER_MS),
    .STRIKE_CYC (STRIKE_MS * CLK_PER_MS),
    .LAMP_W     (LAMP_W),
    .DIM_LIMIT  (DIM_LIMIT)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .lamp_set    (lamp_set),
    .vdd_en      (vdd_en),
    .sig_oe      (sig_oe),
    .lamp_en     (lamp_en),
    .lamp_strike (lamp_strike),
    .dim_duty    (dim_duty),
    .fault       (fault)
);

// File: tb/panel_seq_top_tb.sv
module panel_seq_top_tb_top;
    localparam int CPM  = 4;
    localparam int RAMP = 5;
    localparam int LON  = 8;
    localparam int STK  = 20;
    localparam int LOFF = 6;
    localparam int HOLD = 12;
    localparam int DIML = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_req;
    logic       pwr_good;
    logic [7:0] lamp_set;
    logic       vdd_en, sig_oe, lamp_en, lamp_strike, dim_duty, running, fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    panel_seq_top #(
        .CLK_PER_MS(CPM), .RAMP_MS(RAMP), .LAMP_ON_WAIT_MS(LON), .STRIKE_MS(STK),
        .LAMP_OFF_WAIT_MS(LOFF), .OFF_HOLD_MS(HOLD), .LAMP_W(8), .DIM_LIMIT(DIML)
    ) dut_i (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .pwr_good(pwr_good), .lamp_set(lamp_set),
        .vdd_en(vdd_en), .sig_oe(sig_oe), .lamp_en(lamp_en), .lamp_strike(lamp_strike),
        .dim_duty(dim_duty), .running(running), .fault(fault)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic bit pick(input int which);
        case (which)
            0: return vdd_en;
            1: return sig_oe;
            2: return lamp_en;
            3: return lamp_strike;
            default: return running;
        endcase
    endfunction

    function automatic int exp_dim(input int v);
        return (v < DIML) ? 1 : 0;
    endfunction

    task automatic wait_for(input int which, input bit val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pick(which) != val && n < 20000);
    endtask

    task automatic dim_check(input int v);
        lamp_set = 8'(v);
        @(negedge clk);
        chk("R10 dim_duty", int'(dim_duty), exp_dim(v));
    endtask

    // called right after vdd_en was seen high at a falling edge
    task automatic ramp_and_run(input int gd);
        int n;
        for (int i = 0; i < gd; i++) begin
            @(negedge clk);
            if (sig_oe) chk("R4 sig_oe before good", 1, 0);
        end
        pwr_good = 1'b1;
        wait_for(1, 1'b1, n);
        chk("R4 sig_oe delay after good", n, 1);
        wait_for(2, 1'b1, n);
        chk("R6 lamp_en delay after sig_oe", n, LON * CPM + 1);
        chk("R7 strike with lamp", int'(lamp_strike), 1);
        wait_for(3, 1'b0, n);
        chk("R7 strike length", n, STK * CPM);
        chk("R7 running after strike", int'(running), 1);
        chk("R7 lamp stays on", int'(lamp_en), 1);
    endtask

    task automatic power_down(input bit req_back);
        int n;
        pwr_req = 1'b0;
        wait_for(2, 1'b0, n);
        chk("R8 lamp off delay", n, 1);
        wait_for(1, 1'b0, n);
        chk("R8 sig off delay", n, LOFF * CPM);
        wait_for(0, 1'b0, n);
        chk("R8 vdd off delay", n, 1);
        pwr_good = 1'b0;
        if (req_back) begin
            pwr_req = 1'b1;
            wait_for(0, 1'b1, n);
            chk("R5 off hold then restart", n, HOLD * CPM + 1);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd2718));
        rst = 1'b1; pwr_req = 1'b0; pwr_good = 1'b0; lamp_set = 8'd50;
        repeat (3) @(negedge clk);
        chk("R1 reset vdd_en", int'(vdd_en), 0);
        chk("R1 reset sig_oe", int'(sig_oe), 0);
        chk("R1 reset lamp", int'(lamp_en | lamp_strike | running), 0);
        chk("R1 reset fault/dim", int'(fault | dim_duty), 0);
        pwr_req = 1'b1;
        rst = 1'b0;
        wait_for(0, 1'b1, n);
        chk("R1 hold after reset", n, HOLD * CPM + 1);

        // directed: latest legal power-good
        ramp_and_run(RAMP * CPM - 1);
        dim_check(39); dim_check(40); dim_check(0); dim_check(255);
        power_down(1'b1);

        // random power cycles
        for (int c = 0; c < 4; c++) begin
            ramp_and_run(int'($urandom_range(0, RAMP * CPM - 1)));
            for (int k = 0; k < 3; k++) dim_check(int'($urandom_range(0, 80)));
            power_down(1'b1);
        end

        // ramp timeout
        wait_for(0, 1'b0, n);
        chk("R3 timeout length", n, RAMP * CPM);
        chk("R3 fault raised", int'(fault), 1);
        chk("R3 no sig on timeout", int'(sig_oe), 0);
        wait_for(0, 1'b1, n);
        chk("R5 hold after timeout", n, HOLD * CPM + 1);
        chk("R3 fault cleared on restart", int'(fault), 0);

        // request dropped during ramp
        pwr_req = 1'b0;
        repeat (5) @(negedge clk);
        pwr_good = 1'b1;
        wait_for(1, 1'b1, n);
        chk("R9 sig still rises", n, 1);
        @(negedge clk);
        chk("R9 sig drops next", int'(sig_oe), 0);
        chk("R9 vdd still on", int'(vdd_en), 1);
        @(negedge clk);
        chk("R9 vdd drops", int'(vdd_en), 0);
        chk("R9 lamp never on", int'(lamp_en), 0);
        pwr_good = 1'b0;

        // idle request after hold elapsed
        repeat (HOLD * CPM + 5) @(negedge clk);
        chk("R2 idle vdd low", int'(vdd_en), 0);
        pwr_req = 1'b1;
        wait_for(0, 1'b1, n);
        chk("R2 vdd next cycle", n, 1);

        // request dropped during strike
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        wait_for(2, 1'b1, n);
        repeat (10) @(negedge clk);
        pwr_req = 1'b0;
        wait_for(3, 1'b0, n);
        chk("R9 strike runs full", n, STK * CPM - 10);
        chk("R9 lamp off after strike", int'(lamp_en), 0);
        chk("R9 no running", int'(running), 0);
        wait_for(1, 1'b0, n);
        chk("R8 sig off after lamp wait", n, LOFF * CPM);
        wait_for(0, 1'b0, n);
        chk("R8 vdd after sig", n, 1);
        pwr_good = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule